// File: doc/BRIEF.md
# E1 National-Bit Data Link Unit

This unit carries the national bits Sa4 to Sa8 of an E1 CRC-4 multiframe between a framer's timeslot-0 path and a small register interface. The framer supplies the multiframe position of each basic frame (`frm_num`, 0 to 15) and a strobe when a received timeslot-0 byte is valid. Odd frames are the non-frame-alignment frames; only they carry national bits.

On transmit, the unit rewrites timeslot 0 of each odd frame according to a 2-bit source field. The Sa bits can come from five per-bit transmit bytes held in registers. The whole byte can come from timeslot 0 of a serial-bus input. Otherwise the Sa bits are forced to idle ones. Even frames pass through untouched. On receive, the Sa bits of all eight odd frames are gathered into shadow storage. At the start of the next multiframe they are committed together to five readable receive bytes, and a pulse is given. Every received odd-frame byte is also copied to the serial-bus output byte, whatever the source field says.

Three change monitors watch the received Sa nibbles, where a nibble is the four bits of one Sa position in frames 1-7 or in frames 9-15. They raise sticky status bits, which are cleared by reading them and can be masked individually from the interrupt line.

Top module: `e1_sa_link`

## Requirements
- R1: After reset, all transmit and receive bytes and all status bits read as zero, and `irq`, `mf_pulse` and `sbus_ts0_out` are low or zero.
- R2: When `frm_num` is even, `tx_ts0_out` equals `tx_ts0_in` in every source mode.
- R3: With `src_sel`=00 and `frm_num` odd, `tx_ts0_out[7:5]` equals `tx_ts0_in[7:5]`. Bit `4-i` equals bit `7-(frm_num-1)/2` of transmit byte i, where i=0..4 stands for Sa4..Sa8.
- R4: With `src_sel`=10 and `frm_num` odd, `tx_ts0_out` equals `sbus_ts0_in`.
- R5: With `src_sel`=01 or 11 and `frm_num` odd, `tx_ts0_out[4:0]` is all ones and `tx_ts0_out[7:5]` equals `tx_ts0_in[7:5]`.
- R6: Take a strobe with `frm_num`=0. The cycle after it, receive byte i holds, at bit `7-k`, bit `4-i` of the byte received in frame `2k+1` of the preceding multiframe, and `mf_pulse` is high for that one cycle. The receive bytes do not change on any other cycle.
- R7: One cycle after a strobe in an odd frame, `sbus_ts0_out` equals the received byte. Strobes in even frames leave it unchanged.
- R8: Register map: transmit byte i is read and written at address i (0..4), receive byte i is read at address 8+i, and status is read at address 15. Reads of any other address return zero. Writes to any address other than 0..4 change nothing.
- R9: Status bit 0 sets when a completed nibble (strobes in frames 7 and 15) of any Sa position differs from the previous nibble of that position. The first nibble after reset is never compared.
- R10: Status bit 1 sets when a completed Sa6 nibble differs from the previous Sa6 nibble.
- R11: Status bit 2 sets when the eighth identical Sa6 nibble in a row completes. The run restarts at one on a change and on the first nibble after reset.
- R12: Status bits stay set until a read of address 15 with `rd_en`. That read returns the value before clearing. An event in the same cycle as the read stays set.
- R13: `irq` is high exactly when some status bit is set and its `irq_mask` bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | Received timeslot-0 byte valid |
| frm_num | input | 4 | Basic frame number within the multiframe |
| rx_ts0 | input | 8 | Received timeslot-0 byte, bit position 1 in bit 7 |
| tx_ts0_in | input | 8 | Framer's outgoing timeslot-0 byte |
| tx_ts0_out | output | 8 | Outgoing timeslot-0 byte after Sa insertion |
| sbus_ts0_in | input | 8 | Serial-bus input timeslot-0 byte |
| sbus_ts0_out | output | 8 | Last received odd-frame byte for the serial bus |
| src_sel | input | 2 | Transmit Sa source: 00 buffers, 10 serial bus, 01/11 idle ones |
| irq_mask | input | 3 | Per-status interrupt mask, 1 masks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (clears status at address 15) |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| mf_pulse | output | 1 | Receive bytes freshly committed |
| irq | output | 1 | Interrupt request |

## Verification
A clearing read of the status register and a new nibble event can land in the same cycle. If the set did not win, an Sa6 change occurring in that cycle would be lost. The bench places a clearing read on the frame-15 strobe of a multiframe whose second Sa6 nibble changes. It checks that the read returns the old status and that, afterwards, only the bits set by that nibble remain. Receive commit and nibble completion also meet in this scheme: the bytes committed at frame 0 must not include bits still being gathered, and this is judged by reading them at frames 0 and 9.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  localparam int SA_N   = 5;          // Sa4..Sa8
  localparam int NFAS_N = 8;          // odd frames per multiframe
  localparam int NIB_W  = NFAS_N / 2; // bits per sub-multiframe nibble
  localparam int ST_N   = 3;          // status bits
  localparam int SIX    = 2;          // index of Sa6

  typedef enum logic [1:0] {
    SRC_BUF  = 2'b00,
    SRC_IDLE = 2'b01,
    SRC_SBUS = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  typedef logic [SA_N-1:0][NFAS_N-1:0] sa_bytes_t;

  // bit within a per-Sa byte that holds odd frame frm
  function automatic int buf_bit(input logic [3:0] frm);
    return NFAS_N - 1 - int'(frm[3:1]);
  endfunction

  // bit within the timeslot-0 byte carrying Sa index i (0 = Sa4)
  function automatic int sa_bit(input int i);
    return SA_N - 1 - i;
  endfunction

  // nibble finished by frame frm, with new bit nb merged into shadow byte sh
  function automatic logic [NIB_W-1:0] nib_of(input logic [NFAS_N-1:0] sh,
                                               input logic [3:0] frm,
                                               input logic nb);
    logic [NFAS_N-1:0] t;
    t = sh;
    t[buf_bit(frm)] = nb;
    return frm[3] ? t[NIB_W-1:0] : t[NFAS_N-1:NIB_W];
  endfunction
endpackage

// File: rtl/e1sa_regs.sv
module e1sa_regs
  import e1sa_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int TN_BASE = 0,
  parameter int RN_BASE = 8,
  parameter int ST_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  sa_bytes_t         rn,
  input  logic [ST_N-1:0]   sts_set,
  output sa_bytes_t         tn,
  output logic [ST_N-1:0]   sts,
  output logic [7:0]        rd_data
);
  logic sts_clr;
  assign sts_clr = rd_en && (rd_addr == ADDR_W'(ST_ADDR));

  for (genvar i = 0; i < SA_N; i++) begin : g_tn
    always_ff @(posedge clk) begin
      if (!rst_n)
        tn[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(TN_BASE + i))
        tn[i] <= wr_data;
    end
  end

  // set wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & {ST_N{!sts_clr}}) | sts_set;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < SA_N; i++) begin
      if (rd_addr == ADDR_W'(TN_BASE + i)) rd_data = tn[i];
      if (rd_addr == ADDR_W'(RN_BASE + i)) rd_data = rn[i];
    end
    if (rd_addr == ADDR_W'(ST_ADDR)) rd_data = 8'(sts);
  end
endmodule

// File: rtl/e1sa_tx_mux.sv
module e1sa_tx_mux
  import e1sa_pkg::*;
(
  input  logic [3:0] frm_num,
  input  logic [1:0] src_sel,
  input  logic [7:0] tx_in,
  input  logic [7:0] sbus_in,
  input  sa_bytes_t  tn,
  output logic [7:0] tx_out
);
  always_comb begin
    tx_out = tx_in;
    if (frm_num[0]) begin
      case (src_e'(src_sel))
        SRC_BUF: begin
          for (int i = 0; i < SA_N; i++)
            tx_out[sa_bit(i)] = tn[i][buf_bit(frm_num)];
        end
        SRC_SBUS: tx_out = sbus_in;
        default:  tx_out[SA_N-1:0] = '1;
      endcase
    end
  end
endmodule

// File: rtl/e1sa_rx_cap.sv
module e1sa_rx_cap
  import e1sa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_stb,
  input  logic [3:0] frm_num,
  input  logic [7:0] rx_ts0,
  output sa_bytes_t  shadow,
  output sa_bytes_t  rn,
  output logic [7:0] sbus_out,
  output logic       commit,
  output logic       mf_pulse
);
  assign commit = frm_stb && (frm_num == 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow   <= '0;
      rn       <= '0;
      sbus_out <= '0;
      mf_pulse <= 1'b0;
    end else begin
      mf_pulse <= commit;
      if (commit) rn <= shadow;
      if (frm_stb && frm_num[0]) begin
        sbus_out <= rx_ts0;
        for (int i = 0; i < SA_N; i++)
          shadow[i][buf_bit(frm_num)] <= rx_ts0[sa_bit(i)];
      end
    end
  end
endmodule

// File: rtl/e1sa_nib_mon.sv
module e1sa_nib_mon
  import e1sa_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_stb,
  input  logic [3:0] frm_num,
  input  logic [7:0] rx_ts0,
  input  sa_bytes_t  shadow,
  output logic       nib_done,
  output logic       evt_any,
  output logic       evt_six,
  output logic       evt_run
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [SA_N-1:0][NIB_W-1:0] prev_q, cur;
  logic [SA_N-1:0]            chg;
  logic                       have_prev;
  logic [RUN_W-1:0]           run_q;

  assign nib_done = frm_stb && frm_num[0] && (frm_num[2:0] == 3'b111);

  for (genvar i = 0; i < SA_N; i++) begin : g_nib
    assign cur[i] = nib_of(shadow[i], frm_num, rx_ts0[sa_bit(i)]);
    assign chg[i] = have_prev && (cur[i] != prev_q[i]);
  end

  assign evt_any = nib_done && (|chg);
  assign evt_six = nib_done && chg[SIX];
  assign evt_run = nib_done && have_prev && !chg[SIX] && (run_q == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      have_prev <= 1'b0;
      run_q     <= '0;
    end else if (nib_done) begin
      prev_q    <= cur;
      have_prev <= 1'b1;
      if (!have_prev || chg[SIX])      run_q <= RUN_W'(1);
      else if (run_q != RUN_W'(RUN_LEN)) run_q <= run_q + RUN_W'(1);
    end
  end
endmodule

// File: rtl/e1_sa_link.sv
module e1_sa_link
  import e1sa_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int RUN_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_stb,
  input  logic [3:0]        frm_num,
  input  logic [7:0]        rx_ts0,
  input  logic [7:0]        tx_ts0_in,
  output logic [7:0]        tx_ts0_out,
  input  logic [7:0]        sbus_ts0_in,
  output logic [7:0]        sbus_ts0_out,
  input  logic [1:0]        src_sel,
  input  logic [ST_N-1:0]   irq_mask,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              mf_pulse,
  output logic              irq
);
  sa_bytes_t       tn, rn, shadow;
  logic [ST_N-1:0] sts;
  logic            commit, nib_done, evt_any, evt_six, evt_run;

  e1sa_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr,
    .rn, .sts_set({evt_run, evt_six, evt_any}), .tn, .sts, .rd_data
  );

  e1sa_tx_mux u_tx (
    .frm_num, .src_sel, .tx_in(tx_ts0_in), .sbus_in(sbus_ts0_in), .tn,
    .tx_out(tx_ts0_out)
  );

  e1sa_rx_cap u_rx (
    .clk, .rst_n, .frm_stb, .frm_num, .rx_ts0, .shadow, .rn,
    .sbus_out(sbus_ts0_out), .commit, .mf_pulse
  );

  e1sa_nib_mon #(.RUN_LEN(RUN_LEN)) u_nib (
    .clk, .rst_n, .frm_stb, .frm_num, .rx_ts0, .shadow,
    .nib_done, .evt_any, .evt_six, .evt_run
  );

  assign irq = |(sts & ~irq_mask);
endmodule

// File: rtl/e1sa_chk.sv
module e1sa_chk
  import e1sa_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            frm_stb,
  input logic [3:0]      frm_num,
  input logic [7:0]      tx_ts0_in,
  input logic [7:0]      tx_ts0_out,
  input logic [7:0]      sbus_ts0_in,
  input logic [7:0]      sbus_ts0_out,
  input logic [1:0]      src_sel,
  input logic [ST_N-1:0] irq_mask,
  input logic            rd_en,
  input logic [3:0]      rd_addr,
  input logic            mf_pulse,
  input logic            irq,
  input sa_bytes_t       rn,
  input logic [ST_N-1:0] sts,
  input logic            evt_any,
  input logic            evt_six
);
  p_fas_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_num[0] |-> tx_ts0_out == tx_ts0_in);

  p_sbus_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_num[0] && src_sel == 2'b10) |-> tx_ts0_out == sbus_ts0_in);

  p_idle_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_num[0] && src_sel[0]) |-> tx_ts0_out[4:0] == 5'h1F);

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stb && frm_num == 4'd0) |=> mf_pulse);

  p_rn_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_stb && frm_num == 4'd0) |=> $stable(rn));

  p_sbus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_stb && frm_num[0]) |=> $stable(sbus_ts0_out));

  p_six_in_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_six |-> evt_any);

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == 4'd15) |=> ((sts & $past(sts)) == $past(sts)));

  p_mask_all_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '1) |-> !irq);
endmodule

bind e1_sa_link e1sa_chk u_chk (
  .clk, .rst_n, .frm_stb, .frm_num, .tx_ts0_in, .tx_ts0_out, .sbus_ts0_in,
  .sbus_ts0_out, .src_sel, .irq_mask, .rd_en, .rd_addr, .mf_pulse, .irq,
  .rn, .sts, .evt_any, .evt_six
);

// File: tb/e1_sa_link_tb.sv
`timescale 1ns/100ps
module e1_sa_link_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_stb = 1'b0;
  logic [3:0] frm_num = '0;
  logic [7:0] rx_ts0 = '0, tx_ts0_in = '0, sbus_ts0_in = '0, wr_data = '0;
  logic [7:0] tx_ts0_out, sbus_ts0_out, rd_data;
  logic [1:0] src_sel = '0;
  logic [2:0] irq_mask = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic       mf_pulse, irq;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  e1_sa_link u_dut (
    .clk, .rst_n, .frm_stb, .frm_num, .rx_ts0, .tx_ts0_in, .tx_ts0_out,
    .sbus_ts0_in, .sbus_ts0_out, .src_sel, .irq_mask, .wr_en, .wr_addr,
    .wr_data, .rd_en, .rd_addr, .rd_data, .mf_pulse, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // bench model
  logic [7:0] tn_m [5];
  logic [7:0] sh_m [5];
  logic [7:0] rn_m [5];
  logic [3:0] prev_m [5];
  logic       have_m = 1'b0;
  int         run_m = 0;
  logic [2:0] sts_m = '0;
  logic [7:0] sbus_m = '0;

  function automatic logic [7:0] exp_tx(input int mode, input int f,
                                        input logic [7:0] tin, input logic [7:0] sb);
    logic [4:0] s;
    s = '0;
    if (f % 2 == 0) return tin;
    if (mode == 2) return sb;
    if (mode != 0) return {tin[7:5], 5'b11111};
    for (int i = 0; i < 5; i++) s = {s[3:0], tn_m[i][7 - (f - 1) / 2]};
    return {tin[7:5], s};
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic model_nib(input int f);
    logic [3:0] nb;
    logic       any, six;
    any = 1'b0; six = 1'b0;
    for (int i = 0; i < 5; i++) begin
      nb = (f < 8) ? sh_m[i][7:4] : sh_m[i][3:0];
      if (have_m && nb != prev_m[i]) begin
        any = 1'b1;
        if (i == 2) six = 1'b1;
      end
      prev_m[i] = nb;
    end
    if (!have_m || six) run_m = 1;
    else begin
      if (run_m == 7) sts_m[2] = 1'b1;
      if (run_m < 8) run_m++;
    end
    have_m = 1'b1;
    if (any) sts_m[0] = 1'b1;
    if (six) sts_m[1] = 1'b1;
  endtask

  task automatic send_frame(input int f, input logic [7:0] b, input logic clr);
    logic pulse_e;
    @(negedge clk);
    frm_stb = 1'b1; frm_num = 4'(f); rx_ts0 = b;
    rd_en = clr; rd_addr = 4'd15;
    #0.5;
    if (clr) chk("R12 read returns pre-clear status", 32'(rd_data), 32'(sts_m));
    @(posedge clk);
    if (clr) sts_m = '0;
    pulse_e = (f == 0);
    if (f == 0) for (int i = 0; i < 5; i++) rn_m[i] = sh_m[i];
    if (f % 2 == 1) begin
      sbus_m = b;
      for (int i = 0; i < 5; i++) sh_m[i][7 - f / 2] = b[4 - i];
      if (f % 8 == 7) model_nib(f);
    end
    #1;
    frm_stb = 1'b0; rd_en = 1'b0;
    chk("R6 mf_pulse", 32'(mf_pulse), 32'(pulse_e));
    chk("R7 serial-bus output byte", 32'(sbus_ts0_out), 32'(sbus_m));
    if (f == 0 || f == 9) begin
      for (int i = 0; i < 5; i++) begin
        rd_addr = 4'(8 + i); #0.1;
        chk("R6 receive byte", 32'(rd_data), 32'(rn_m[i]));
      end
      rd_addr = 4'd15;
    end
    #0.1;
    chk("R9 any-Sa change status", 32'(rd_data[0]), 32'(sts_m[0]));
    chk("R10 Sa6 change status", 32'(rd_data[1]), 32'(sts_m[1]));
    chk("R11 Sa6 run status", 32'(rd_data[2]), 32'(sts_m[2]));
    chk("R12 upper status bits zero", 32'(rd_data[7:3]), 32'h0);
    chk("R13 irq", 32'(irq), 32'(|(sts_m & ~irq_mask)));
  endtask

  logic [7:0] pat [8][5];
  logic [2:0] msk [8];

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) begin sh_m[i] = '0; rn_m[i] = '0; prev_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a); #0.1;
      chk("R1 register reset value", 32'(rd_data), 32'h0);
    end
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 mf_pulse after reset", 32'(mf_pulse), 32'h0);
    chk("R1 serial-bus output after reset", 32'(sbus_ts0_out), 32'h0);

    // R8 register write and readback
    for (int i = 0; i < 5; i++) begin
      tn_m[i] = 8'(8'h3C ^ (i * 8'h51));
      wr(i, tn_m[i]);
    end
    for (int a = 5; a < 16; a++) wr(a, 8'hFF);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      rd_addr = 4'(i); #0.1;
      chk("R8 transmit byte readback", 32'(rd_data), 32'(tn_m[i]));
      rd_addr = 4'(8 + i); #0.1;
      chk("R8 receive byte untouched by write", 32'(rd_data), 32'h0);
    end
    for (int a = 5; a < 8; a++) begin
      rd_addr = 4'(a); #0.1;
      chk("R8 unmapped address reads zero", 32'(rd_data), 32'h0);
    end
    rd_addr = 4'd15; #0.1;
    chk("R8 status untouched by write", 32'(rd_data), 32'h0);

    // R2..R5 transmit sweep
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 16; f++) begin
        for (int v = 0; v < 2; v++) begin
          @(negedge clk);
          src_sel = 2'(m); frm_num = 4'(f);
          tx_ts0_in = v ? 8'h1B : 8'hE4;
          sbus_ts0_in = 8'(8'h69 ^ f);
          #0.5;
          if (f % 2 == 0)
            chk("R2 even frame pass-through", 32'(tx_ts0_out), 32'(exp_tx(m, f, tx_ts0_in, sbus_ts0_in)));
          else if (m == 0)
            chk("R3 buffer source", 32'(tx_ts0_out), 32'(exp_tx(m, f, tx_ts0_in, sbus_ts0_in)));
          else if (m == 2)
            chk("R4 serial-bus source", 32'(tx_ts0_out), 32'(exp_tx(m, f, tx_ts0_in, sbus_ts0_in)));
          else
            chk("R5 idle ones", 32'(tx_ts0_out), 32'(exp_tx(m, f, tx_ts0_in, sbus_ts0_in)));
        end
      end
    end

    // receive scenarios: Sa4..Sa8 bytes per multiframe
    for (int k = 0; k < 4; k++) begin
      pat[k] = '{8'hFF, 8'h00, 8'hCC, 8'h33, 8'hAA};
      msk[k] = 3'b000;
    end
    pat[4] = '{8'hFF, 8'h00, 8'hCC, 8'h3F, 8'hAA}; msk[4] = 3'b110;
    pat[5] = '{8'hFF, 8'h00, 8'hC5, 8'h3F, 8'hAA}; msk[5] = 3'b011;
    pat[6] = '{8'h55, 8'h00, 8'h55, 8'h3F, 8'hAA}; msk[6] = 3'b101;
    pat[7] = '{8'h55, 8'h00, 8'h55, 8'h3F, 8'hAA}; msk[7] = 3'b111;
    for (int mf = 0; mf < 8; mf++) begin
      irq_mask = msk[mf];
      for (int f = 0; f < 16; f++) begin
        logic [7:0] b;
        logic       clr;
        if (f % 2 == 1) begin
          b = {3'(f), 5'b0};
          for (int i = 0; i < 5; i++) b[4 - i] = pat[mf][i][7 - f / 2];
        end else b = 8'h1B;
        // clearing read, colliding with a nibble event in multiframe 5 frame 15
        clr = (mf >= 4 && f == 1) || (mf == 5 && f == 15);
        send_frame(f, b, clr);
      end
    end
    send_frame(0, 8'h1B, 1'b0);
    send_frame(1, 8'h00, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule